// File: doc/BRIEF.md
# I2C Clock-Stretch Wait and Interrupt Controller

This block watches the SCL and SDA lines of an I2C bus. It counts the SCL clock cycles of each byte, shifts in the received bits and raises a sticky transfer-complete interrupt at a programmable wait point, either the 8th or the 9th rising SCL edge. At the next falling edge of SCL after that point it pulls SCL low and holds it there, which stretches the clock until software writes a self-clearing release bit. It also detects stop conditions, which can be included as an interrupt source. It compares the first byte after a start condition with a slave address, in either bit order, and can acknowledge on the ninth clock by pulling SDA low.

Both lines are open drain. The block drives them only through output enables, and the driven level is always 0. Between transfers a clock-level bit either pulls SCL low or leaves it released, so that software can form start and stop conditions by hand. SCL and SDA pass through a two-stage synchronizer, so each line event is seen three clock cycles after the pin changes.

Top module: `i2c_wait_ctrl`

## Requirements
- R1: After reset the control register reads 0x00. Its layout is: bit 0 stop-interrupt enable, bit 1 address order, bit 2 idle-high, bit 3 release, bits 5:4 wait select, bit 6 live SCL level (read-only), bit 7 always 0. Every field except bit 6 and bit 7 reads back the value last written.
- R2: Wait select 2 sets the wait point at the 8th rising SCL edge and 3 sets it at the 9th. With 0 or 1 there is no wait point: no interrupt is raised and no wait is entered.
- R3: The interrupt flag (intReq) rises on the clock edge that detects the wait-point rising edge, which is three clocks after the pin rises. It stays set until intClr is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R4: After the wait-point rising edge, the next falling edge of SCL asserts sclOe, and sclOe stays asserted until the wait is released.
- R5: Writing 1 to the release bit makes it read 1 for exactly one cycle. At the end of that cycle the wait ends, sclOe drops and the clock counter returns to zero. The bit then reads 0.
- R6: While enabled and with no transfer in progress (between a stop and the next start), sclOe equals the inverse of the idle-high bit.
- R7: A stop condition (SDA rising while SCL is high) sets the interrupt flag when the stop-interrupt bit is 1, and has no effect on the flag when the bit is 0.
- R8: Bit 6 of the control register shows the synchronized SCL level while enable is 1, and reads 0 while enable is 0.
- R9: At the 8th rising edge of the first byte after a start, addrHit is updated. It becomes 1 when the received byte matches slaveAddr. With the address-order bit at 1, the first received bit is compared with slaveAddr bit 7. With it at 0, the first received bit is compared with slaveAddr bit 0. A start condition clears addrHit.
- R10: When ackEn is 1 during a transfer, sdaOe asserts at the SCL falling edge that follows the 8th counted rising edge, and drops at the next falling edge.
- R11: A start condition resets the clock counter. Driving enable to 0 clears the transfer state and deasserts both output enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Serial interface enable |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 8 | Control register write data |
| ctrlRdData | output | 8 | Control register read data |
| intClr | input | 1 | Clears the sticky interrupt flag |
| slaveAddr | input | DATA_W | Own slave address |
| ackEn | input | 1 | Acknowledge on the ninth clock |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| intReq | output | 1 | Sticky interrupt flag |
| addrHit | output | 1 | First byte matched the slave address |

## Verification
A wrong clock count or a wrong wait-arm state shows at the ports within one SCL period. The interrupt flag would rise on the wrong rising edge, or sclOe would assert on the wrong falling edge, or the line would never be released. An event decoded in the wrong synchronizer stage shifts every output by whole cycles, so the per-clock comparison against a behavioural model catches it on the first edge. A wrong address order or a wrong shift sequence appears on addrHit three cycles after the 8th rising edge of the first byte.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [1:0] {
    WS_OFF0  = 2'd0,
    WS_OFF1  = 2'd1,
    WS_EIGHT = 2'd2,
    WS_NINE  = 2'd3
  } waitSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic hold;
  } dpCmd_t;

  // decoded line events from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
  } lineEv_t;

endpackage

// File: rtl/i2cw_datapath.sv
module i2cw_datapath
  import i2cw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCmd_t            cmd,
  input  logic              addrMsbFirst,
  input  logic [DATA_W-1:0] slaveAddr,
  output lineEv_t           ev,
  output logic              sclLevel,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              addrHit
);

  localparam logic [CNT_W-1:0] LAST_ADDR_CNT = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclDly, sdaDly, sclNow, sdaNow;
  logic [DATA_W-1:0] shReg, addrRev, addrRef, rxNext;
  logic firstByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe[0] <= 1'b1;
      sdaPipe[0] <= 1'b1;
    end else begin
      sclPipe[0] <= sclIn;
      sdaPipe[0] <= sdaIn;
    end
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sclPipe[i] <= 1'b1;
        sdaPipe[i] <= 1'b1;
      end else begin
        sclPipe[i] <= sclPipe[i-1];
        sdaPipe[i] <= sdaPipe[i-1];
      end
    end
  end

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclDly <= 1'b1;
      sdaDly <= 1'b1;
    end else begin
      sclDly <= sclNow;
      sdaDly <= sdaNow;
    end
  end

  always_comb begin
    ev.sclRise  = sclNow & ~sclDly;
    ev.sclFall  = ~sclNow & sclDly;
    ev.startDet = sdaDly & ~sdaNow & sclNow & sclDly;
    ev.stopDet  = ~sdaDly & sdaNow & sclNow & sclDly;
  end

  assign sclLevel = sclNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (cmd.hold || cmd.cntClear || ev.startDet) begin
      bitCnt <= '0;
    end else if (ev.sclRise && bitCnt != '1) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign rxNext = {shReg[DATA_W-2:0], sdaNow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (ev.sclRise) begin
      shReg <= rxNext;
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign addrRev[b] = slaveAddr[DATA_W-1-b];
  end

  assign addrRef = addrMsbFirst ? slaveAddr : addrRev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstByte <= 1'b0;
      addrHit   <= 1'b0;
    end else if (cmd.hold) begin
      firstByte <= 1'b0;
      addrHit   <= 1'b0;
    end else if (ev.startDet) begin
      firstByte <= 1'b1;
      addrHit   <= 1'b0;
    end else if (ev.sclRise && firstByte && bitCnt == LAST_ADDR_CNT) begin
      firstByte <= 1'b0;
      addrHit   <= (rxNext == addrRef);
    end
  end

  // R11: a start condition always leaves the counter at zero
  p_cnt_start_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    ev.startDet |=> bitCnt == '0);

endmodule

// File: rtl/i2cw_control.sv
module i2cw_control
  import i2cw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             ctrlWrEn,
  input  logic [7:0]       ctrlWrData,
  input  logic             intClr,
  input  logic             ackEn,
  input  lineEv_t          ev,
  input  logic             sclLevel,
  input  logic [CNT_W-1:0] bitCnt,
  output dpCmd_t           cmd,
  output logic             addrMsbFirst,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             intReq,
  output logic [7:0]       ctrlRdData
);

  localparam logic [CNT_W:0]   POINT_8  = (CNT_W+1)'(DATA_W);
  localparam logic [CNT_W:0]   POINT_9  = (CNT_W+1)'(DATA_W + 1);
  localparam logic [CNT_W-1:0] ACK_CNT  = CNT_W'(DATA_W);

  waitSel_e waitSel;
  logic relBit, idleHigh, stopIrq;
  logic busy, waitArm, waiting, intFlag, ackDrive;
  logic waitOn, hitPoint, flagSet;
  logic [CNT_W:0] nextCnt, waitPoint;
  logic unusedWrBits;

  assign unusedWrBits = ^ctrlWrData[7:6];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitSel      <= WS_OFF0;
      relBit       <= 1'b0;
      idleHigh     <= 1'b0;
      addrMsbFirst <= 1'b0;
      stopIrq      <= 1'b0;
    end else if (ctrlWrEn) begin
      waitSel      <= waitSel_e'(ctrlWrData[5:4]);
      relBit       <= ctrlWrData[3];
      idleHigh     <= ctrlWrData[2];
      addrMsbFirst <= ctrlWrData[1];
      stopIrq      <= ctrlWrData[0];
    end else if (relBit) begin
      relBit <= 1'b0;
    end
  end

  assign waitOn    = (waitSel == WS_EIGHT) || (waitSel == WS_NINE);
  assign waitPoint = (waitSel == WS_NINE) ? POINT_9 : POINT_8;
  assign nextCnt   = {1'b0, bitCnt} + 1'b1;
  assign hitPoint  = ev.sclRise && busy && waitOn && (nextCnt == waitPoint);
  assign flagSet   = hitPoint || (enable && stopIrq && ev.stopDet);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              busy <= 1'b0;
    else if (!enable)       busy <= 1'b0;
    else if (ev.startDet)   busy <= 1'b1;
    else if (ev.stopDet)    busy <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitArm <= 1'b0;
      waiting <= 1'b0;
    end else if (!enable || relBit) begin
      waitArm <= 1'b0;
      waiting <= 1'b0;
    end else if (hitPoint) begin
      waitArm <= 1'b1;
    end else if (ev.sclFall && waitArm) begin
      waitArm <= 1'b0;
      waiting <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         intFlag <= 1'b0;
    else if (flagSet)  intFlag <= 1'b1;
    else if (intClr)   intFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackDrive <= 1'b0;
    end else if (!enable || ev.startDet) begin
      ackDrive <= 1'b0;
    end else if (ev.sclFall) begin
      if (ackDrive) ackDrive <= 1'b0;
      else          ackDrive <= busy && ackEn && (bitCnt == ACK_CNT);
    end
  end

  assign cmd.cntClear = relBit;
  assign cmd.hold     = ~enable;

  assign sclOe  = enable && (busy ? waiting : ~idleHigh);
  assign sdaOe  = enable && ackDrive;
  assign intReq = intFlag;

  assign ctrlRdData = {1'b0, enable & sclLevel, waitSel, relBit,
                       idleHigh, addrMsbFirst, stopIrq};

  // R5: the release bit never survives a cycle without a fresh write
  p_rel_selfclear_r5: assert property (@(posedge clk) disable iff (!rstN)
    relBit && !ctrlWrEn |=> !relBit);

  // R4: the stretch only ever begins on a falling SCL edge
  p_wait_on_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waiting) |-> $past(ev.sclFall));

  // R3: the flag is sticky until cleared
  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    intFlag && !intClr |=> intFlag);

  // R10: acknowledge drive starts while SCL is low
  p_ack_on_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> $past(ev.sclFall));

endmodule

// File: rtl/i2c_wait_ctrl.sv
module i2c_wait_ctrl
  import i2cw_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              ctrlWrEn,
  input  logic [7:0]        ctrlWrData,
  output logic [7:0]        ctrlRdData,
  input  logic              intClr,
  input  logic [DATA_W-1:0] slaveAddr,
  input  logic              ackEn,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              intReq,
  output logic              addrHit
);

  localparam int CNT_W = $clog2(DATA_W + 2);

  dpCmd_t           cmd;
  lineEv_t          ev;
  logic             sclLevel, addrMsbFirst;
  logic [CNT_W-1:0] bitCnt;

  i2cw_datapath #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .cmd(cmd),
    .addrMsbFirst(addrMsbFirst), .slaveAddr(slaveAddr), .ev(ev),
    .sclLevel(sclLevel), .bitCnt(bitCnt), .addrHit(addrHit)
  );

  i2cw_control #(
    .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .intClr(intClr), .ackEn(ackEn), .ev(ev),
    .sclLevel(sclLevel), .bitCnt(bitCnt), .cmd(cmd),
    .addrMsbFirst(addrMsbFirst), .sclOe(sclOe), .sdaOe(sdaOe),
    .intReq(intReq), .ctrlRdData(ctrlRdData)
  );

endmodule

// File: tb/i2c_wait_ctrl_test.sv
module i2c_wait_ctrl_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = 8'h00;
  logic intClr = 1'b0;
  logic [7:0] slaveAddr = 8'h3C;
  logic ackEn = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sclIn, sdaIn;
  logic [7:0] ctrlRdData;
  logic sclOe, sdaOe, intReq, addrHit;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  assign sclIn = mScl & ~sclOe;
  assign sdaIn = mSda & ~sdaOe;

  i2c_wait_ctrl uut (
    .clk(clk), .rstN(rstN), .enable(enable), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .ctrlRdData(ctrlRdData), .intClr(intClr),
    .slaveAddr(slaveAddr), .ackEn(ackEn), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclOe(sclOe), .sdaOe(sdaOe), .intReq(intReq), .addrHit(addrHit)
  );

  // behavioural reference model
  int s1c = 1, s2c = 1, dc = 1, s1d = 1, s2d = 1, dd = 1;
  int mWs = 0, mRel = 0, mIdle = 0, mMsb = 0, mStop = 0;
  int mBusy = 0, mArm = 0, mWait = 0, mFlag = 0, mAck = 0;
  int mCnt = 0, mFirst = 0, mHit = 0, mSh = 0;

  function automatic int revByte(input int v);
    int r = 0;
    for (int i = 0; i < 8; i++) if (((v >> i) & 1) != 0) r = r | (1 << (7 - i));
    return r;
  endfunction

  always @(posedge clk) begin
    int rise, fall, st, sp, hit, en, rel, rx, pt;
    if (!rstN) begin
      s1c = 1; s2c = 1; dc = 1; s1d = 1; s2d = 1; dd = 1;
      mWs = 0; mRel = 0; mIdle = 0; mMsb = 0; mStop = 0;
      mBusy = 0; mArm = 0; mWait = 0; mFlag = 0; mAck = 0;
      mCnt = 0; mFirst = 0; mHit = 0; mSh = 0;
    end else begin
      en   = enable ? 1 : 0;
      rel  = mRel;
      rise = (s2c == 1 && dc == 0) ? 1 : 0;
      fall = (s2c == 0 && dc == 1) ? 1 : 0;
      st   = (dd == 1 && s2d == 0 && s2c == 1 && dc == 1) ? 1 : 0;
      sp   = (dd == 0 && s2d == 1 && s2c == 1 && dc == 1) ? 1 : 0;
      pt   = (mWs == 3) ? 9 : 8;
      hit  = (rise == 1 && mBusy == 1 && mWs >= 2 && mCnt + 1 == pt) ? 1 : 0;
      rx   = ((mSh << 1) | s2d) & 255;
      // acknowledge drive
      if (en == 0 || st == 1) mAck = 0;
      else if (fall == 1) mAck = (mAck == 1) ? 0 : ((mBusy == 1 && ackEn && mCnt == 8) ? 1 : 0);
      // wait state
      if (en == 0 || rel == 1) begin mArm = 0; mWait = 0; end
      else if (hit == 1) mArm = 1;
      else if (fall == 1 && mArm == 1) begin mArm = 0; mWait = 1; end
      // interrupt flag
      if (hit == 1 || (en == 1 && mStop == 1 && sp == 1)) mFlag = 1;
      else if (intClr) mFlag = 0;
      // transfer in progress
      if (en == 0) mBusy = 0;
      else if (st == 1) mBusy = 1;
      else if (sp == 1) mBusy = 0;
      // address compare
      if (en == 0) begin mFirst = 0; mHit = 0; end
      else if (st == 1) begin mFirst = 1; mHit = 0; end
      else if (rise == 1 && mFirst == 1 && mCnt == 7) begin
        mFirst = 0;
        mHit = (rx == ((mMsb == 1) ? int'(slaveAddr) : revByte(int'(slaveAddr)))) ? 1 : 0;
      end
      // clock counter
      if (en == 0 || rel == 1 || st == 1) mCnt = 0;
      else if (rise == 1 && mCnt < 15) mCnt = mCnt + 1;
      if (rise == 1) mSh = rx;
      // control register
      if (ctrlWrEn) begin
        mWs = (ctrlWrData >> 4) & 3; mRel = ctrlWrData[3]; mIdle = ctrlWrData[2];
        mMsb = ctrlWrData[1]; mStop = ctrlWrData[0];
      end else if (mRel == 1) mRel = 0;
      // synchronizers
      dc = s2c; s2c = s1c; s1c = sclIn;
      dd = s2d; s2d = s1d; s1d = sdaIn;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int en, expRd;
    if (rstN) begin
      en = enable ? 1 : 0;
      expRd = ((en & s2c) << 6) | (mWs << 4) | (mRel << 3) | (mIdle << 2) | (mMsb << 1) | mStop;
      check("R4 R6 R11 sclOe", int'(sclOe), (en == 1) ? ((mBusy == 1) ? mWait : 1 - mIdle) : 0);
      check("R10 R11 sdaOe", int'(sdaOe), en & mAck);
      check("R2 R3 R7 intReq", int'(intReq), mFlag);
      check("R9 addrHit", int'(addrHit), mHit);
      check("R1 R5 R8 ctrlRdData", int'(ctrlRdData), expRd);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [1:0] ws, input logic rel, input logic idle,
                        input logic msb, input logic stp);
    @(negedge clk);
    ctrlWrEn = 1'b1;
    ctrlWrData = {2'b00, ws, rel, idle, msb, stp};
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic clrInt();
    @(negedge clk); intClr = 1'b1;
    @(negedge clk); intClr = 1'b0;
  endtask

  task automatic startCond();
    mSda = 1'b1; mScl = 1'b1; tick(8);
    mSda = 1'b0; tick(8);
    mScl = 1'b0; tick(6);
  endtask

  task automatic stopCond();
    mSda = 1'b0; tick(5);
    mScl = 1'b1; tick(8);
    mSda = 1'b1; tick(8);
  endtask

  task automatic clockBit(input logic b);
    mSda = b; tick(5);
    mScl = 1'b1; tick(7);
    mScl = 1'b0; tick(5);
  endtask

  task automatic sendByte(input logic [7:0] v, input logic msbFirst);
    for (int i = 0; i < 8; i++) clockBit(msbFirst ? v[7-i] : v[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;                       // R1 reset state compared from here
    tick(4);
    // R8: disabled block shows SCL level 0 and drives nothing
    wrCtrl(2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
    tick(6);
    enable = 1'b1;
    tick(6);
    // R2 R3 R4 R9 R10: 9-clock wait, MSB-first address match, acknowledge
    ackEn = 1'b1;
    slaveAddr = 8'h3C;
    startCond();
    sendByte(8'h3C, 1'b1);
    clockBit(1'b1);
    tick(20);                          // R4 stretch held
    clrInt();                          // R3 clear
    wrCtrl(2'd3, 1'b1, 1'b1, 1'b1, 1'b0);  // R5 release
    tick(6);
    stopCond();                        // R7 stop ignored with bit 0
    tick(6);
    // R2 R7 R9: 8-clock wait, LSB-first order, stop interrupt
    wrCtrl(2'd2, 1'b0, 1'b1, 1'b0, 1'b1);
    slaveAddr = 8'hA6;
    startCond();
    sendByte(8'hA6, 1'b0);
    tick(15);
    clrInt();
    wrCtrl(2'd2, 1'b1, 1'b1, 1'b0, 1'b1);
    tick(4);
    clockBit(1'b1);                    // R10 acknowledge after release
    stopCond();
    tick(6);
    clrInt();
    // R2 R9 R11: no wait point, mismatched address, start mid-byte
    wrCtrl(2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    startCond();
    clockBit(1'b1);
    clockBit(1'b0);
    mSda = 1'b1; tick(4); mScl = 1'b1; tick(6);
    startCond();                       // repeated start resets the count
    sendByte(8'h55, 1'b1);
    clockBit(1'b1);
    sendByte(8'hFF, 1'b1);
    stopCond();
    // R1 bit 7 and bit 6 ignore writes
    @(negedge clk); ctrlWrEn = 1'b1; ctrlWrData = 8'hC4;
    @(negedge clk); ctrlWrEn = 1'b0;
    tick(4);
    // R5 release written while idle reads 1 for one cycle
    wrCtrl(2'd1, 1'b1, 1'b1, 1'b0, 1'b0);
    tick(4);
    // R6: idle level low drives SCL
    wrCtrl(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    tick(10);
    // R11: disable releases everything
    enable = 1'b0;
    tick(10);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule